// File: doc/BRIEF.md
# Two-Wire Serial Slave Packet Engine

This block is the slave side of a two-wire serial bus. The clock line and the data line arrive as raw inputs. Each passes through a synchronizer clocked by the system clock, and edge logic then finds rising and falling clock edges and the bus START and STOP conditions. After a START, the first nine-bit packet is read as an address packet: seven address bits, most significant first, then a direction bit. The engine compares the address with its own configurable address and with the all-zero general-call address. When it accepts, it pulls the data line low in the ninth clock cycle. After that it either receives data bytes and presents each one on a parallel output, or it shifts out bytes supplied on a parallel input and watches the master's acknowledge.

The data line output is open-drain style. `sda_drive_low` high means the engine pulls the line low, and low means the line is released. The engine changes this output only in the cycle after a falling clock edge, a START or a STOP. It never acknowledges the reserved 1111xxx group or a general call with the read bit. It refuses with a NACK while `busy` is high.

The controller has eight states:
- ST_IDLE: waits for a START.
- ST_ADDR: shifts in the address packet.
- ST_ADDR_ACK: drives the address acknowledge.
- ST_RX: shifts in a data byte.
- ST_RX_ACK: drives the data acknowledge.
- ST_TX: shifts out a byte.
- ST_TX_ACK: samples the master's acknowledge.
- ST_SKIP: releases the line and waits for the next START or STOP.

The transitions are:
- START from any state goes to ST_ADDR. STOP from any state goes to ST_IDLE.
- From ST_ADDR, on the falling edge after the eighth bit: to ST_ADDR_ACK if the address is accepted, otherwise to ST_SKIP.
- From ST_ADDR_ACK, on the next falling edge: to ST_TX for a read, or to ST_RX for a write.
- From ST_RX, after eight bits: to ST_RX_ACK.
- From ST_RX_ACK: back to ST_RX if the byte was acknowledged, otherwise to ST_SKIP.
- From ST_TX, after eight bits: to ST_TX_ACK.
- From ST_TX_ACK: back to ST_TX if the master acknowledged, otherwise to ST_SKIP.

Top module: `tws_packet_engine`

## Requirements
- R1: A START (data line falling while the clock line is high) moves the engine to address reception from any state, even in the middle of a packet. It releases the data line, and a repeated START after a packet begins a new transfer.
- R2: A STOP (data line rising while the clock line is high) returns the engine to idle with the data line released. No output is driven until the next START.
- R3: The address packet is seven address bits sent most significant first, then a direction bit where 1 means read and 0 means write. A match with `own_addr` and the write bit is acknowledged by driving low through the ninth clock cycle. Each following data byte is taken most significant first, acknowledged, and presented on `rx_byte` with a one-cycle `rx_valid` pulse and `rx_general` low.
- R4: An address that matches neither `own_addr` nor an enabled general call is left unacknowledged. The data line stays released for the rest of that transfer.
- R5: Address 0000000 with the write bit is acknowledged only while `gc_enable` is high. Its data bytes are then received and acknowledged with `rx_general` high.
- R6: Address 0000000 with the read bit is never acknowledged.
- R7: Any address whose top four bits are 1111 is never acknowledged, even when `own_addr` equals it.
- R8: While `busy` is high at the end of the address packet, a matching address is left unacknowledged.
- R9: While `busy` is high at the end of a data byte, that byte is left unacknowledged, `rx_valid` does not pulse, and later bytes of the transfer are ignored.
- R10: In a read, `tx_byte` is shifted out most significant bit first. A 0 bit is driven low and a 1 bit is released. The drive level changes only in the cycle after a falling clock edge, a START or a STOP.
- R11: A master acknowledge after a read byte loads the next `tx_byte`. A master NACK releases the data line, and the engine ignores the bus until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw clock line level |
| sda_in | input | 1 | Raw data line level (bus value) |
| own_addr | input | 7 | Own slave address |
| gc_enable | input | 1 | Allow general-call write acceptance |
| busy | input | 1 | Refuse address or data with NACK |
| tx_byte | input | 8 | Byte to send in a read transfer |
| sda_drive_low | output | 1 | 1 = pull data line low, 0 = release |
| rx_byte | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle pulse when rx_byte is new |
| rx_general | output | 1 | Received byte belongs to a general call |

## Verification
The embedded assertions check four things on every cycle:
- the drive output changes only right after a falling clock edge, a START or a STOP;
- the START, STOP and clock-edge events never coincide;
- an acknowledge is never driven for a reserved address or for a general-call read;
- a received byte is never presented while `busy` was high.

Other behaviours need whole bus transactions, so only the bench's scenarios can show them. These are the bit order of addresses and data, the choice between own-address and general-call acceptance, the NACK-driven skipping of the rest of a transfer, the reload of read bytes on a master acknowledge, and recovery through repeated START in mid-byte.

// File: rtl/tws_pkg.sv
package tws_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } tws_state_e;
endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_p;
    logic              sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_p    <= scl_pipe[STAGES-1];
            sda_p    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

    // R1: bus conditions and clock edges are mutually exclusive events
    assert_events_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall, start_det, stop_det}));
endmodule

// File: rtl/tws_addr_filter.sv
module tws_addr_filter #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rw,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_enable,
    input  logic              busy,
    output logic              accept,
    output logic              is_general
);
    localparam int RSV_BITS = 4;

    logic reserved;
    logic hit_own;
    logic hit_gc;

    always_comb begin
        is_general = (addr == '0);
        reserved   = &addr[ADDR_W-1 -: RSV_BITS];
        hit_own    = (addr == own_addr) && !is_general;
        hit_gc     = is_general && gc_enable && !rw;
        accept     = !busy && !reserved && (hit_own || hit_gc);
    end
endmodule

// File: rtl/tws_packet_engine.sv
module tws_packet_engine
    import tws_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_enable,
    input  logic              busy,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              sda_drive_low,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_general
);
    localparam int ABITS = ADDR_W + 1;
    localparam int SH_W  = (ABITS > DATA_W) ? ABITS : DATA_W;
    localparam int CNT_W = $clog2(SH_W + 1);

    tws_state_e        state, state_n;
    logic [SH_W-1:0]   sh;
    logic [DATA_W-1:0] tx_sh;
    logic [CNT_W-1:0]  cnt;
    logic              ack_q;
    logic              mack_q;

    logic scl_s, sda_s, scl_rise_w, scl_fall_w, start_w, stop_w;
    logic accept_w, general_w;
    logic addr_done, byte_done;

    tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .start_det (start_w),
        .stop_det  (stop_w)
    );

    tws_addr_filter #(.ADDR_W(ADDR_W)) u_filter (
        .addr       (sh[ADDR_W:1]),
        .rw         (sh[0]),
        .own_addr   (own_addr),
        .gc_enable  (gc_enable),
        .busy       (busy),
        .accept     (accept_w),
        .is_general (general_w)
    );

    assign addr_done = scl_fall_w && (cnt == CNT_W'(ABITS));
    assign byte_done = scl_fall_w && (cnt == CNT_W'(DATA_W));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        if (start_w) begin
            state_n = ST_ADDR;
        end else if (stop_w) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_ADDR:     if (addr_done)  state_n = accept_w ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall_w) state_n = sh[0] ? ST_TX : ST_RX;
                ST_RX:       if (byte_done)  state_n = ST_RX_ACK;
                ST_RX_ACK:   if (scl_fall_w) state_n = ack_q ? ST_RX : ST_SKIP;
                ST_TX:       if (byte_done)  state_n = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall_w) state_n = mack_q ? ST_TX : ST_SKIP;
                ST_SKIP:     state_n = ST_SKIP;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh            <= '0;
            tx_sh         <= '0;
            cnt           <= '0;
            ack_q         <= 1'b0;
            mack_q        <= 1'b0;
            sda_drive_low <= 1'b0;
            rx_byte       <= '0;
            rx_valid      <= 1'b0;
            rx_general    <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (start_w || stop_w) begin
                cnt           <= '0;
                sda_drive_low <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise_w) begin
                            sh  <= {sh[SH_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end
                        if (addr_done) begin
                            sda_drive_low <= accept_w;
                            rx_general    <= general_w;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall_w) begin
                            cnt <= '0;
                            if (sh[0]) begin
                                tx_sh         <= tx_byte;
                                sda_drive_low <= ~tx_byte[DATA_W-1];
                            end else begin
                                sda_drive_low <= 1'b0;
                            end
                        end
                    end
                    ST_RX: begin
                        if (scl_rise_w) begin
                            sh  <= {sh[SH_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end
                        if (byte_done) begin
                            ack_q         <= !busy;
                            sda_drive_low <= !busy;
                            if (!busy) begin
                                rx_byte  <= sh[DATA_W-1:0];
                                rx_valid <= 1'b1;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall_w) begin
                            sda_drive_low <= 1'b0;
                            cnt           <= '0;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise_w) cnt <= cnt + 1'b1;
                        if (byte_done) begin
                            sda_drive_low <= 1'b0;
                        end else if (scl_fall_w) begin
                            tx_sh         <= tx_sh << 1;
                            sda_drive_low <= ~tx_sh[DATA_W-2];
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise_w) mack_q <= ~sda_s;
                        if (scl_fall_w) begin
                            cnt <= '0;
                            if (mack_q) begin
                                tx_sh         <= tx_byte;
                                sda_drive_low <= ~tx_byte[DATA_W-1];
                            end else begin
                                sda_drive_low <= 1'b0;
                            end
                        end
                    end
                    default: sda_drive_low <= 1'b0;
                endcase
            end
        end
    end

    // R10: drive level only moves right after a falling clock edge or a bus condition
    assert_drive_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> $past(scl_fall_w || start_w || stop_w));

    // R2: idle means the line is released
    assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_drive_low);

    // R7: reserved group never reaches the acknowledge state
    assert_no_reserved_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> !(&sh[ADDR_W -: 4]));

    // R6: general-call read never reaches the acknowledge state
    assert_no_gc_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && sh[ADDR_W:1] == '0) |-> !sh[0]);

    // R9: a byte is presented only if busy was low when it completed
    assert_valid_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(!busy));
endmodule

// File: tb/sim_tws_packet_engine.sv
`timescale 1ns/1ps
module sim_tws_packet_engine;
    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [6:0] own_addr = 7'h2A;
    logic       gc_enable = 1'b0;
    logic       busy = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       sda_drive_low;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       rx_general;
    wire        sda_bus = sda_m & ~sda_drive_low;

    int checks = 0;
    int failures = 0;
    int guard = 0;
    logic exp_drive = 1'b0;
    logic [8:0] exp_q[$];
    logic last_bit;

    always #5 clk = ~clk;

    tws_packet_engine u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .own_addr(own_addr), .gc_enable(gc_enable), .busy(busy), .tx_byte(tx_byte),
        .sda_drive_low(sda_drive_low), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_general(rx_general)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model comparison, every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (guard > 0) guard--;
            else chk(sda_drive_low == exp_drive, "R10 drive level", sda_drive_low, exp_drive);
            if (rx_valid) begin
                if (exp_q.size() == 0) chk(0, "R9 unexpected rx_valid", rx_byte, 0);
                else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk({rx_general, rx_byte} == e, "R3 rx byte", {rx_general, rx_byte}, e);
                end
            end
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clk_bit(input logic b, input logic exp_after);
        sda_m = b;
        waitc(H);
        scl_m = 1'b1;
        waitc(H / 2);
        last_bit = sda_bus;
        waitc(H / 2);
        scl_m = 1'b0;
        exp_drive = exp_after;
        guard = 6;
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        waitc(H);
        scl_m = 1'b1;
        waitc(H);
        sda_m = 1'b0;
        exp_drive = 1'b0;
        guard = 6;
        waitc(H);
        scl_m = 1'b0;
        guard = 6;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        waitc(H);
        scl_m = 1'b1;
        waitc(H);
        sda_m = 1'b1;
        exp_drive = 1'b0;
        guard = 6;
        waitc(H);
    endtask

    task automatic send_addr(input logic [6:0] a, input logic rw, input logic acc, input string req);
        for (int i = 0; i < 7; i++) clk_bit(a[6-i], 1'b0);
        clk_bit(rw, acc);
        clk_bit(1'b1, (acc && rw) ? ~tx_byte[7] : 1'b0);
        chk(last_bit == !acc, req, last_bit, !acc);
    endtask

    task automatic send_data(input logic [7:0] b, input logic acc, input logic gen, input string req);
        for (int i = 0; i < 8; i++) clk_bit(b[7-i], (i == 7) ? acc : 1'b0);
        if (acc) exp_q.push_back({gen, b});
        clk_bit(1'b1, 1'b0);
        chk(last_bit == !acc, req, last_bit, !acc);
    endtask

    task automatic read_data(input logic [7:0] b, input logic mack, input logic [7:0] nxt);
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, (i < 7) ? ~b[6-i] : 1'b0);
            chk(last_bit == b[7-i], "R10 read bit", last_bit, b[7-i]);
        end
        tx_byte = nxt;
        clk_bit(mack ? 1'b0 : 1'b1, mack ? ~nxt[7] : 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        waitc(5);
        chk(sda_drive_low == 1'b0 && rx_valid == 1'b0, "R2 reset state", sda_drive_low, 0);
        rst_n = 1'b1;
        waitc(5);

        // R3: own address write, several bytes
        bus_start();
        send_addr(7'h2A, 1'b0, 1'b1, "R3 own addr ack");
        send_data(8'hC3, 1'b1, 1'b0, "R3 data ack");
        send_data(8'h5A, 1'b1, 1'b0, "R3 data ack");
        send_data(8'h01, 1'b1, 1'b0, "R3 data ack");
        bus_stop();
        waitc(10);
        chk(sda_drive_low == 1'b0, "R2 released after stop", sda_drive_low, 0);

        // R4: other address ignored, bytes not acknowledged
        bus_start();
        send_addr(7'h15, 1'b0, 1'b0, "R4 mismatch nack");
        send_data(8'h00, 1'b0, 1'b0, "R4 data ignored");
        bus_stop();

        // R5: general call disabled then enabled
        bus_start();
        send_addr(7'h00, 1'b0, 1'b0, "R5 gc disabled nack");
        bus_stop();
        gc_enable = 1'b1;
        bus_start();
        send_addr(7'h00, 1'b0, 1'b1, "R5 gc enabled ack");
        send_data(8'h9E, 1'b1, 1'b1, "R5 gc data");
        send_data(8'h07, 1'b1, 1'b1, "R5 gc data");
        bus_stop();

        // R6: general call read refused
        bus_start();
        send_addr(7'h00, 1'b1, 1'b0, "R6 gc read nack");
        bus_stop();

        // R7: reserved group refused even as own address
        own_addr = 7'h7A;
        bus_start();
        send_addr(7'h7A, 1'b0, 1'b0, "R7 reserved nack");
        bus_stop();
        own_addr = 7'h2A;

        // R8: busy at address
        busy = 1'b1;
        bus_start();
        send_addr(7'h2A, 1'b0, 1'b0, "R8 busy nack");
        bus_stop();
        busy = 1'b0;

        // R9: busy during data
        bus_start();
        send_addr(7'h2A, 1'b0, 1'b1, "R9 addr ack");
        send_data(8'h44, 1'b1, 1'b0, "R9 first byte ack");
        busy = 1'b1;
        send_data(8'h55, 1'b0, 1'b0, "R9 busy byte nack");
        busy = 1'b0;
        send_data(8'h66, 1'b0, 1'b0, "R9 later byte ignored");
        bus_stop();

        // R10/R11: read with master ack then nack, then repeated start (R1)
        tx_byte = 8'hA5;
        bus_start();
        send_addr(7'h2A, 1'b1, 1'b1, "R10 read addr ack");
        read_data(8'hA5, 1'b1, 8'h3C);
        read_data(8'h3C, 1'b0, 8'hFF);
        waitc(20);
        chk(sda_drive_low == 1'b0, "R11 released after master nack", sda_drive_low, 0);
        bus_start();
        send_addr(7'h2A, 1'b0, 1'b1, "R1 repeated start ack");
        send_data(8'h81, 1'b1, 1'b0, "R1 data after repeated start");
        // R1: START in the middle of a byte restarts address reception
        clk_bit(1'b0, 1'b0);
        clk_bit(1'b1, 1'b0);
        clk_bit(1'b0, 1'b0);
        bus_start();
        send_addr(7'h2A, 1'b0, 1'b1, "R1 mid-byte restart ack");
        send_data(8'h7E, 1'b1, 1'b0, "R1 data after restart");
        bus_stop();
        waitc(20);
        chk(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule